// File: doc/BRIEF.md
# Boot Sector Decoder and Write Protection Gate

This block sits between the command decoder of a parallel flash device and its array control. It turns an incoming word address into the number of one of eleven erase sectors. The sectors have unequal sizes: four small boot sectors are packed into one end of the address space, and seven large sectors fill the rest. A parameter chooses whether the small sectors sit at the high end (top boot) or at the low end (bottom boot). The two layouts are mirror images of each other.

The block keeps one protection bit for each sector. Only a separate privileged port can change these bits. Every program, sector-erase or chip-erase request is checked against the effective protection. A protected target is refused. A temporary-unprotect input lifts all protection while it is high. The stored bits are not touched by it, so they apply again as soon as the input falls. A chip erase returns the mask of the sectors it may clear.

The block also supplies the identification read data: the manufacturer code, the device code and a per-sector protection flag. In byte mode the extra least-significant byte address lies below the word address and does not affect anything here.

Top module: `boot_sector_guard`

## Requirements
- R1: With TOP_BOOT = 0 the sector number on `sector_o` follows word-address bits 17..12. Bits 17..13 = 00000 give sector 0 (8 Kword). Bits 17..12 = 000010 and 000011 give sectors 1 and 2 (4 Kword each). Bits 17..14 = 0001 give sector 3 (16 Kword). Bits 17..15 = 001 to 111 give sectors 4 to 10 (32 Kword each).
- R2: With TOP_BOOT = 1 the layout is mirrored. Bits 17..15 = 000 to 110 give sectors 0 to 6. Bits 17..14 = 1110 give sector 7. Bits 17..12 = 111100 and 111101 give sectors 8 and 9. Bits 17..13 = 11111 give sector 10.
- R3: After reset every sector is unprotected.
- R4: A program (`req_kind_i` = 00) or sector erase (01) aimed at a sector whose effective protection is set gives a reject with an all-zero mask.
- R5: A program or sector erase aimed at an unprotected sector gives a grant, with a mask holding only that sector's bit.
- R6: While `tmp_unprot_i` is high, every request is treated as if no sector were protected. Once it falls, the stored protection applies again unchanged.
- R7: A chip erase (10) returns the mask of the sectors that are not effectively protected and is granted. If that mask is zero, the chip erase is rejected. Kind 11 is always rejected with a zero mask.
- R8: A protection bit changes only through the privileged port (`prot_we_i`, `prot_sector_i`, `prot_set_i`), one clock edge after the write. Requests and the temporary-unprotect input never change the bits.
- R9: An identification read with address bits 1..0 = 00 returns the manufacturer code 01h on bits 7..0 and 00h on bits 15..8.
- R10: An identification read with address bits 1..0 = 01 returns the device code on bits 7..0: B9h for top boot, BAh for bottom boot. Bits 15..8 carry 22h in word mode and 00h in byte mode.
- R11: An identification read with address bits 1..0 = 10 returns 01h if the stored protection bit of the addressed sector is set, and 00h if it is clear. Address bits 1..0 = 11 return 0000h.
- R12: A request sampled at one rising edge is answered in the same cycle. `resp_valid_o` is high for that one cycle, with exactly one of `grant_o` and `reject_o`. With no request, all three outputs and the mask are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address; bits 17..12 pick the sector, bits 1..0 pick the identification item |
| byte_mode_i | input | 1 | High selects byte mode for identification data |
| req_valid_i | input | 1 | Request strobe |
| req_kind_i | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 reserved |
| tmp_unprot_i | input | 1 | Temporary-unprotect override |
| prot_we_i | input | 1 | Privileged protection write strobe |
| prot_sector_i | input | SECT_W | Sector written by the privileged port |
| prot_set_i | input | 1 | New protection value for that sector |
| sector_o | output | SECT_W | Decoded sector of addr_i |
| resp_valid_o | output | 1 | Response strobe |
| grant_o | output | 1 | Request accepted |
| reject_o | output | 1 | Request refused |
| erase_mask_o | output | NUM_SECT | Sectors the accepted operation may touch |
| id_data_o | output | 16 | Identification read data |

## Verification
A wrong boundary in the sector decode shows up at once on `sector_o` for addresses next to that boundary. It also appears one cycle later in a one-hot mask that points at the wrong sector. A corrupted or stuck protection bit cannot hide: the protection-verify read shows it on `id_data_o` in the same cycle it is addressed. It also flips the next request to that sector from grant to reject, or the other way round, one edge later. If the override leaks into the stored state, it appears as a wrong protect flag right after `tmp_unprot_i` falls.

// File: rtl/boot_sector_pkg.sv
package boot_sector_pkg;

   localparam int NUM_SECT = 11;
   localparam int SECT_W   = $clog2(NUM_SECT);

   typedef enum logic [1:0] {
      REQ_PROG   = 2'b00,
      REQ_SERASE = 2'b01,
      REQ_CERASE = 2'b10,
      REQ_RSVD   = 2'b11
   } req_kind_e;

   typedef enum logic [1:0] {
      ID_MFR    = 2'b00,
      ID_DEV    = 2'b01,
      ID_PROT   = 2'b10,
      ID_UNUSED = 2'b11
   } id_item_e;

endpackage

// File: rtl/bsg_sector_decode.sv
module bsg_sector_decode
   import boot_sector_pkg::*;
#(
   parameter int ADDR_W   = 18,
   parameter bit TOP_BOOT = 1'b0
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [SECT_W-1:0] sector_o
);
   localparam int HI_W = 6;

   logic [HI_W-1:0] hi;
   assign hi = addr_i[ADDR_W-1 -: HI_W];

   generate
      if (TOP_BOOT) begin : g_top
         always_comb begin
            if (hi[5:3] != 3'b111)
               sector_o = SECT_W'(hi[5:3]);
            else if (hi[2] == 1'b0)
               sector_o = SECT_W'(7);
            else if (hi[1] == 1'b0)
               sector_o = SECT_W'(8) + SECT_W'(hi[0]);
            else
               sector_o = SECT_W'(10);
         end
      end else begin : g_bottom
         always_comb begin
            if (hi[5:3] != 3'b000)
               sector_o = SECT_W'(hi[5:3]) + SECT_W'(3);
            else if (hi[2] == 1'b1)
               sector_o = SECT_W'(3);
            else if (hi[1] == 1'b1)
               sector_o = SECT_W'(1) + SECT_W'(hi[0]);
            else
               sector_o = SECT_W'(0);
         end
      end
   endgenerate

   always_comb begin
      a_r1_sector_in_range : assert (sector_o < SECT_W'(NUM_SECT) || $isunknown(addr_i));
   end
endmodule

// File: rtl/bsg_prot_store.sv
module bsg_prot_store
   import boot_sector_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                prot_we_i,
   input  logic [SECT_W-1:0]   prot_sector_i,
   input  logic                prot_set_i,
   input  logic                tmp_unprot_i,
   output logic [NUM_SECT-1:0] prot_stored_o,
   output logic [NUM_SECT-1:0] prot_eff_o
);
   logic [NUM_SECT-1:0] prot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prot_q <= '0;
      else if (prot_we_i && prot_sector_i < SECT_W'(NUM_SECT))
         prot_q[prot_sector_i] <= prot_set_i;
   end

   assign prot_stored_o = prot_q;
   assign prot_eff_o    = tmp_unprot_i ? '0 : prot_q;

   a_r8_only_priv_port : assert property (@(posedge clk) disable iff (!rst_n)
      !$past(prot_we_i) |-> $stable(prot_q));

   a_r8_single_bit : assert property (@(posedge clk) disable iff (!rst_n)
      $past(prot_we_i) |-> $countones(prot_q ^ $past(prot_q)) <= 1);

   a_r6_override_keeps_store : assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(tmp_unprot_i) && !$past(prot_we_i)) |-> $stable(prot_stored_o));
endmodule

// File: rtl/bsg_req_gate.sv
module bsg_req_gate
   import boot_sector_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid_i,
   input  logic [1:0]          req_kind_i,
   input  logic [SECT_W-1:0]   sector_i,
   input  logic [NUM_SECT-1:0] prot_eff_i,
   output logic                resp_valid_o,
   output logic                grant_o,
   output logic                reject_o,
   output logic [NUM_SECT-1:0] erase_mask_o
);
   logic [NUM_SECT-1:0] target_onehot;
   logic [NUM_SECT-1:0] open_sectors;
   logic [NUM_SECT-1:0] mask_d;
   logic                ok_d;

   always_comb begin
      target_onehot = '0;
      for (int i = 0; i < NUM_SECT; i++)
         target_onehot[i] = (sector_i == SECT_W'(i));
   end

   assign open_sectors = ~prot_eff_i;

   always_comb begin
      mask_d = '0;
      ok_d   = 1'b0;
      unique case (req_kind_e'(req_kind_i))
         REQ_PROG, REQ_SERASE: begin
            ok_d   = |(target_onehot & open_sectors);
            mask_d = ok_d ? target_onehot : '0;
         end
         REQ_CERASE: begin
            mask_d = open_sectors;
            ok_d   = |open_sectors;
         end
         default: begin
            mask_d = '0;
            ok_d   = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid_o <= 1'b0;
         grant_o      <= 1'b0;
         reject_o     <= 1'b0;
         erase_mask_o <= '0;
      end else begin
         resp_valid_o <= req_valid_i;
         grant_o      <= req_valid_i && ok_d;
         reject_o     <= req_valid_i && !ok_d;
         erase_mask_o <= req_valid_i ? mask_d : '0;
      end
   end

   a_r12_one_outcome : assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid_o |-> (grant_o ^ reject_o));

   a_r12_quiet_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !resp_valid_o |-> (!grant_o && !reject_o && erase_mask_o == '0));

   a_r4_protected_refused : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && !req_kind_i[1] && prot_eff_i[sector_i])
      |=> (reject_o && erase_mask_o == '0));

   a_r5_single_target : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && !req_kind_i[1]) |=> $onehot0(erase_mask_o));

   a_r7_chip_skips_protected : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_kind_i == 2'b10)
      |=> ((erase_mask_o & $past(prot_eff_i)) == '0));
endmodule

// File: rtl/bsg_id_mux.sv
module bsg_id_mux
   import boot_sector_pkg::*;
#(
   parameter bit         TOP_BOOT = 1'b0,
   parameter logic [7:0] MFR_CODE = 8'h01,
   parameter logic [7:0] DEV_TOP  = 8'hB9,
   parameter logic [7:0] DEV_BOT  = 8'hBA,
   parameter logic [7:0] DEV_HI   = 8'h22
) (
   input  logic [1:0]          item_i,
   input  logic                byte_mode_i,
   input  logic [SECT_W-1:0]   sector_i,
   input  logic [NUM_SECT-1:0] prot_stored_i,
   output logic [15:0]         data_o
);
   localparam logic [7:0] DEV_LO = TOP_BOOT ? DEV_TOP : DEV_BOT;

   logic flag;
   assign flag = (sector_i < SECT_W'(NUM_SECT)) ? prot_stored_i[sector_i] : 1'b0;

   always_comb begin
      unique case (id_item_e'(item_i))
         ID_MFR:  data_o = {8'h00, MFR_CODE};
         ID_DEV:  data_o = {(byte_mode_i ? 8'h00 : DEV_HI), DEV_LO};
         ID_PROT: data_o = {15'h0000, flag};
         default: data_o = 16'h0000;
      endcase
   end
endmodule

// File: rtl/boot_sector_guard.sv
module boot_sector_guard
   import boot_sector_pkg::*;
#(
   parameter int         ADDR_W   = 18,
   parameter bit         TOP_BOOT = 1'b0,
   parameter logic [7:0] MFR_CODE = 8'h01,
   parameter logic [7:0] DEV_TOP  = 8'hB9,
   parameter logic [7:0] DEV_BOT  = 8'hBA,
   parameter logic [7:0] DEV_HI   = 8'h22
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic                byte_mode_i,
   input  logic                req_valid_i,
   input  logic [1:0]          req_kind_i,
   input  logic                tmp_unprot_i,
   input  logic                prot_we_i,
   input  logic [SECT_W-1:0]   prot_sector_i,
   input  logic                prot_set_i,
   output logic [SECT_W-1:0]   sector_o,
   output logic                resp_valid_o,
   output logic                grant_o,
   output logic                reject_o,
   output logic [NUM_SECT-1:0] erase_mask_o,
   output logic [15:0]         id_data_o
);
   generate
      if (ADDR_W < 8) begin : g_bad_addr_w
         $error("boot_sector_guard: ADDR_W must be at least 8");
      end
   endgenerate

   logic [NUM_SECT-1:0] prot_stored;
   logic [NUM_SECT-1:0] prot_eff;

   bsg_sector_decode #(
      .ADDR_W   (ADDR_W),
      .TOP_BOOT (TOP_BOOT)
   ) u_decode (
      .addr_i   (addr_i),
      .sector_o (sector_o)
   );

   bsg_prot_store u_store (
      .clk           (clk),
      .rst_n         (rst_n),
      .prot_we_i     (prot_we_i),
      .prot_sector_i (prot_sector_i),
      .prot_set_i    (prot_set_i),
      .tmp_unprot_i  (tmp_unprot_i),
      .prot_stored_o (prot_stored),
      .prot_eff_o    (prot_eff)
   );

   bsg_req_gate u_gate (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid_i  (req_valid_i),
      .req_kind_i   (req_kind_i),
      .sector_i     (sector_o),
      .prot_eff_i   (prot_eff),
      .resp_valid_o (resp_valid_o),
      .grant_o      (grant_o),
      .reject_o     (reject_o),
      .erase_mask_o (erase_mask_o)
   );

   bsg_id_mux #(
      .TOP_BOOT (TOP_BOOT),
      .MFR_CODE (MFR_CODE),
      .DEV_TOP  (DEV_TOP),
      .DEV_BOT  (DEV_BOT),
      .DEV_HI   (DEV_HI)
   ) u_id (
      .item_i        (addr_i[1:0]),
      .byte_mode_i   (byte_mode_i),
      .sector_i      (sector_o),
      .prot_stored_i (prot_stored),
      .data_o        (id_data_o)
   );

   a_r6_override_grants : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && tmp_unprot_i && req_kind_i != 2'b11) |=> grant_o);

   a_r3_clear_after_reset : assert property (@(posedge clk)
      $rose(rst_n) |-> (prot_stored == '0));
endmodule

// File: tb/boot_sector_guard_bench.sv
module boot_sector_guard_bench;
   import boot_sector_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 18;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic byte_mode = 1'b0;
   logic req_valid = 1'b0;
   logic [1:0] req_kind = 2'b00;
   logic tmp_unprot = 1'b0;
   logic prot_we = 1'b0;
   logic [SECT_W-1:0] prot_sector = '0;
   logic prot_set = 1'b0;

   logic [SECT_W-1:0] sector_b, sector_t;
   logic resp_valid, grant, reject;
   logic [NUM_SECT-1:0] mask;
   logic [15:0] id_b, id_t;
   logic rv_t, gr_t, rj_t;
   logic [NUM_SECT-1:0] mk_t;

   always #(CLK_PERIOD/2) clk = ~clk;

   boot_sector_guard #(.ADDR_W(AW), .TOP_BOOT(1'b0)) u_boot_sector_guard (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .byte_mode_i(byte_mode),
      .req_valid_i(req_valid), .req_kind_i(req_kind), .tmp_unprot_i(tmp_unprot),
      .prot_we_i(prot_we), .prot_sector_i(prot_sector), .prot_set_i(prot_set),
      .sector_o(sector_b), .resp_valid_o(resp_valid), .grant_o(grant),
      .reject_o(reject), .erase_mask_o(mask), .id_data_o(id_b));

   boot_sector_guard #(.ADDR_W(AW), .TOP_BOOT(1'b1)) u_boot_sector_guard_top (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .byte_mode_i(byte_mode),
      .req_valid_i(1'b0), .req_kind_i(2'b00), .tmp_unprot_i(1'b0),
      .prot_we_i(1'b0), .prot_sector_i('0), .prot_set_i(1'b0),
      .sector_o(sector_t), .resp_valid_o(rv_t), .grant_o(gr_t),
      .reject_o(rj_t), .erase_mask_o(mk_t), .id_data_o(id_t));

   int n_checks = 0;
   int n_fail = 0;
   logic [NUM_SECT-1:0] model_prot = '0;

   typedef struct packed {
      logic grant;
      logic reject;
      logic [NUM_SECT-1:0] mask;
   } resp_t;

   resp_t exp_q[$];
   string tag_q[$];

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int ref_bottom(input logic [AW-1:0] a);
      if (a < 18'h02000) return 0;
      if (a < 18'h03000) return 1;
      if (a < 18'h04000) return 2;
      if (a < 18'h08000) return 3;
      return int'(a >> 15) + 3;
   endfunction

   function automatic int ref_top(input logic [AW-1:0] a);
      if (a < 18'h38000) return int'(a >> 15);
      if (a < 18'h3C000) return 7;
      if (a < 18'h3D000) return 8;
      if (a < 18'h3E000) return 9;
      return 10;
   endfunction

   task automatic do_req(input string tag, input logic [1:0] kind,
                         input logic [AW-1:0] a, input logic tmp);
      resp_t e;
      logic [NUM_SECT-1:0] eff;
      int s;
      eff = tmp ? '0 : model_prot;
      s = ref_bottom(a);
      e = '0;
      if (kind == 2'b00 || kind == 2'b01) begin
         e.grant = !eff[s];
         e.mask = e.grant ? (NUM_SECT'(1) << s) : '0;
      end else if (kind == 2'b10) begin
         e.mask = ~eff;
         e.grant = |e.mask;
      end
      e.reject = !e.grant;
      @(negedge clk);
      addr = a; req_kind = kind; tmp_unprot = tmp; req_valid = 1'b1;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic prot_write(input int s, input logic v);
      @(negedge clk);
      prot_we = 1'b1; prot_sector = SECT_W'(s); prot_set = v;
      @(negedge clk);
      prot_we = 1'b0;
      model_prot[s] = v;
   endtask

   // Monitor: pops expected responses as the design produces them
   always @(negedge clk) begin
      if (rst_n) begin
         if (resp_valid) begin
            if (exp_q.size() == 0) begin
               check("R12 unexpected response", 32'(resp_valid), 32'h0);
            end else begin
               resp_t e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(t, {19'h0, grant, reject, mask}, {19'h0, e.grant, e.reject, e.mask});
            end
         end else begin
            check("R12 idle outputs", {19'h0, grant, reject, mask}, 32'h0);
         end
      end
   end

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [AW-1:0] pts[16] = '{18'h00000, 18'h01FFF, 18'h02000, 18'h02FFF,
                                 18'h03000, 18'h03FFF, 18'h04000, 18'h07FFF,
                                 18'h08000, 18'h1FFFF, 18'h37FFF, 18'h38000,
                                 18'h3BFFF, 18'h3C000, 18'h3D000, 18'h3FFFF};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: reset state
      check("R12 reset resp_valid", 32'(resp_valid), 32'h0);
      for (int s = 0; s < NUM_SECT; s++) begin
         addr = {AW'(0)} | (AW'(s == 0 ? 18'h00000 : s == 1 ? 18'h02000 :
                s == 2 ? 18'h03000 : s == 3 ? 18'h04000 : (s - 3) << 15)) | AW'(2);
         #1;
         check("R3 reset unprotected flag", 32'(id_b), 32'h0);
      end

      // R1 / R2: decode at boundaries
      for (int i = 0; i < 16; i++) begin
         addr = pts[i];
         #1;
         check("R1 bottom decode", 32'(sector_b), 32'(ref_bottom(pts[i])));
         check("R2 top decode", 32'(sector_t), 32'(ref_top(pts[i])));
      end

      // R9 / R10: identification
      addr = 18'h00000; byte_mode = 1'b0; #1;
      check("R9 manufacturer", 32'(id_b), 32'h0001);
      addr = 18'h00001; #1;
      check("R10 bottom device word", 32'(id_b), 32'h22BA);
      check("R10 top device word", 32'(id_t), 32'h22B9);
      byte_mode = 1'b1; #1;
      check("R10 bottom device byte", 32'(id_b), 32'h00BA);
      check("R10 top device byte", 32'(id_t), 32'h00B9);
      byte_mode = 1'b0;
      addr = 18'h00003; #1;
      check("R11 unused item", 32'(id_b), 32'h0000);

      // R5 / R7 with nothing protected
      do_req("R5 program open sector 0", 2'b00, 18'h00100, 1'b0);
      do_req("R5 sector erase sector 10", 2'b01, 18'h3F000, 1'b0);
      do_req("R7 chip erase all open", 2'b10, 18'h00000, 1'b0);
      do_req("R7 reserved kind", 2'b11, 18'h00000, 1'b0);

      // R8: protect sectors 1, 3, 9 via privileged port
      prot_write(1, 1'b1);
      prot_write(3, 1'b1);
      prot_write(9, 1'b1);
      addr = 18'h02002; #1;
      check("R11 sector 1 protected", 32'(id_b), 32'h0001);
      addr = 18'h03002; #1;
      check("R11 sector 2 unprotected", 32'(id_b), 32'h0000);

      // R4 / R5 / R7 with protection
      do_req("R4 program protected sector 1", 2'b00, 18'h02abc, 1'b0);
      do_req("R4 erase protected sector 3", 2'b01, 18'h05000, 1'b0);
      do_req("R5 program open sector 2", 2'b00, 18'h03100, 1'b0);
      do_req("R7 chip erase partial mask", 2'b10, 18'h00000, 1'b0);

      // R6: override
      do_req("R6 override program sector 1", 2'b00, 18'h02000, 1'b1);
      do_req("R6 override chip erase", 2'b10, 18'h00000, 1'b1);
      @(negedge clk);
      tmp_unprot = 1'b1;
      addr = 18'h30002; #1;
      check("R8 flag kept during override", 32'(id_b), 32'h0001);
      @(negedge clk);
      tmp_unprot = 1'b0;
      do_req("R6 protection back after override", 2'b00, 18'h30000, 1'b0);

      // R8: requests did not alter stored bits
      @(negedge clk);
      addr = 18'h04002; #1;
      check("R8 sector 3 still protected", 32'(id_b), 32'h0001);
      addr = 18'h00002; #1;
      check("R8 sector 0 still open", 32'(id_b), 32'h0000);

      // R8: unprotect via port
      prot_write(3, 1'b0);
      do_req("R8 sector 3 open after port clear", 2'b01, 18'h07FFF, 1'b0);

      // R7: all protected
      for (int s = 0; s < NUM_SECT; s++) prot_write(s, 1'b1);
      do_req("R7 chip erase all protected", 2'b10, 18'h00000, 1'b0);
      do_req("R4 program all protected", 2'b00, 18'h3FFFF, 1'b0);

      repeat (3) @(negedge clk);
      check("R12 scoreboard drained", 32'(exp_q.size()), 32'h0);
      finish_run();
   end
endmodule